// File: doc/BRIEF.md
# Three-Multiplier Complex Twiddle Multiplier

This block rotates a complex data sample by a complex twiddle coefficient inside a pipelined FFT stage, placed after the butterfly pair. It forms the product with three real multipliers instead of four. The coefficient store supplies the twiddle real part, its imaginary part, and their sum. The imaginary part is already stored with the sign of the negative sine, so the block forms a plain product and never conjugates.

The three products are a shared term, the data real part times the coefficient sum, and two cross terms. The cross terms are the data sum times the coefficient imaginary part and the data difference times the coefficient real part. The real result is the shared term minus the first cross term. The imaginary result is the shared term plus the second cross term. Both sums are rounded to the output width.

Three register stages follow the pre-adders, the multipliers and the final add/subtract. A valid flag travels through a matching three-deep pipeline. The pipeline has no state machine beyond that valid chain, so it accepts a new sample on every clock.

Top module: `twiddle_cmul3`

## Requirements
- R1: When `tw_sum` equals `tw_re + tw_im`, `out_re` equals round(`in_re*tw_re - in_im*tw_im`), where round(x) = (x + 2^(CW-2)) >> (CW-1), with an arithmetic shift, kept to the low OW bits.
- R2: When `tw_sum` equals `tw_re + tw_im`, `out_im` equals round(`in_re*tw_im + in_im*tw_re`).
- R3: Rounding is round-half-up. An exact +0.5 LSB result rounds to +1, and an exact -0.5 LSB result rounds to 0.
- R4: The most negative operand values on all four inputs give the exact result. That result is out_re = 0 and out_im = 2^DW at the default widths, with no wrap.
- R5: `out_valid` is asserted exactly 3 cycles after `in_valid`. Samples offered on consecutive cycles come out on consecutive cycles, in order.
- R6: While `rst_n` is low, and after it is released, `out_valid` is 0 until a valid sample has passed through.
- R7: The block uses `tw_sum` as given and never recomputes it. `out_re` = round(`in_re*tw_sum - (in_re+in_im)*tw_im`). `out_im` = round(`in_re*tw_sum + (in_im-in_re)*tw_re`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_re | input | DW | Data real part, signed |
| in_im | input | DW | Data imaginary part, signed |
| tw_re | input | CW | Twiddle real part, signed, CW-1 fraction bits |
| tw_im | input | CW | Twiddle imaginary part (negative sine), signed |
| tw_sum | input | CW+1 | Precomputed tw_re + tw_im, signed |
| out_valid | output | 1 | Output valid, 3 cycles after in_valid |
| out_re | output | OW | Rounded real product, signed |
| out_im | output | OW | Rounded imaginary product, signed |

## Verification
Every result is due on the third rising edge after the edge that captured the sample. The bench drives inputs on falling edges and reads the outputs on the third falling edge after the drive. It also confirms that `out_valid` is still low one falling edge earlier. Streaming runs check the output on each falling edge against the expected value for the sample driven three falling edges before. Expected values come from a four-product reference, or from the three-product formula when the coefficient sum is deliberately inconsistent.

// File: rtl/cmul3_pkg.sv
package cmul3_pkg;
    typedef enum logic [1:0] {
        MUL_SHARED = 2'd0,
        MUL_RE     = 2'd1,
        MUL_IM     = 2'd2
    } mul_sel_e;

    localparam int NUM_MULS = 3;
    localparam int PIPE_LAT = 3;
endpackage

// File: rtl/cm_preadd.sv
module cm_preadd
    import cmul3_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16,
    localparam int SW = DW + 1,
    localparam int TW = CW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] ar,
    input  logic signed [DW-1:0] ai,
    input  logic signed [CW-1:0] br,
    input  logic signed [CW-1:0] bi,
    input  logic signed [TW-1:0] bsum,
    output logic signed [SW-1:0] op_a_q [NUM_MULS],
    output logic signed [TW-1:0] op_b_q [NUM_MULS]
);
    logic signed [SW-1:0] op_a_d [NUM_MULS];
    logic signed [TW-1:0] op_b_d [NUM_MULS];

    always_comb begin
        op_a_d[MUL_SHARED] = SW'(ar);
        op_b_d[MUL_SHARED] = bsum;
        op_a_d[MUL_RE]     = SW'(ar) + SW'(ai);
        op_b_d[MUL_RE]     = TW'(bi);
        op_a_d[MUL_IM]     = SW'(ai) - SW'(ar);
        op_b_d[MUL_IM]     = TW'(br);
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NUM_MULS; k++) begin
            if (!rst_n) begin
                op_a_q[k] <= '0;
                op_b_q[k] <= '0;
            end else begin
                op_a_q[k] <= op_a_d[k];
                op_b_q[k] <= op_b_d[k];
            end
        end
    end
endmodule

// File: rtl/cm_mult_bank.sv
module cm_mult_bank
    import cmul3_pkg::*;
#(
    parameter int SW = 17,
    parameter int TW = 17,
    localparam int PW = SW + TW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [SW-1:0] op_a [NUM_MULS],
    input  logic signed [TW-1:0] op_b [NUM_MULS],
    output logic signed [PW-1:0] prod_q [NUM_MULS]
);
    for (genvar k = 0; k < NUM_MULS; k++) begin : g_mul
        logic signed [PW-1:0] prod_d;
        assign prod_d = PW'(op_a[k]) * PW'(op_b[k]);

        always_ff @(posedge clk) begin
            if (!rst_n) prod_q[k] <= '0;
            else        prod_q[k] <= prod_d;
        end
    end
endmodule

// File: rtl/cm_combine.sv
module cm_combine
    import cmul3_pkg::*;
#(
    parameter int PW = 34,
    parameter int CW = 16,
    parameter int OW = 18,
    localparam int FW    = PW + 1,
    localparam int SHIFT = CW - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [PW-1:0] prod [NUM_MULS],
    output logic signed [OW-1:0] res_re_q,
    output logic signed [OW-1:0] res_im_q
);
    localparam logic signed [FW-1:0] HALF = FW'(1) <<< (SHIFT - 1);

    logic signed [FW-1:0] full_re, full_im;

    always_comb begin
        full_re = FW'(prod[MUL_SHARED]) - FW'(prod[MUL_RE]);
        full_im = FW'(prod[MUL_SHARED]) + FW'(prod[MUL_IM]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_re_q <= '0;
            res_im_q <= '0;
        end else begin
            res_re_q <= OW'((full_re + HALF) >>> SHIFT);
            res_im_q <= OW'((full_im + HALF) >>> SHIFT);
        end
    end
endmodule

// File: rtl/twiddle_cmul3.sv
module twiddle_cmul3
    import cmul3_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int OW = DW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    input  logic signed [CW-1:0] tw_re,
    input  logic signed [CW-1:0] tw_im,
    input  logic signed [CW:0]   tw_sum,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_re,
    output logic signed [OW-1:0] out_im
);
    localparam int SW = DW + 1;
    localparam int TW = CW + 1;
    localparam int PW = SW + TW;

    logic signed [SW-1:0] op_a [NUM_MULS];
    logic signed [TW-1:0] op_b [NUM_MULS];
    logic signed [PW-1:0] prod [NUM_MULS];
    logic [PIPE_LAT-1:0]  vld_q;

    cm_preadd #(.DW(DW), .CW(CW)) u_preadd (
        .clk(clk), .rst_n(rst_n), .ar(in_re), .ai(in_im),
        .br(tw_re), .bi(tw_im), .bsum(tw_sum),
        .op_a_q(op_a), .op_b_q(op_b)
    );

    cm_mult_bank #(.SW(SW), .TW(TW)) u_mult (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod_q(prod)
    );

    cm_combine #(.PW(PW), .CW(CW), .OW(OW)) u_combine (
        .clk(clk), .rst_n(rst_n), .prod(prod),
        .res_re_q(out_re), .res_im_q(out_im)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[PIPE_LAT-2:0], in_valid};
    end

    assign out_valid = vld_q[PIPE_LAT-1];

    // Four-product reference, used only by the checks below
    localparam int FW = PW + 1;
    localparam logic signed [FW-1:0] REF_HALF = FW'(1) <<< (CW - 2);
    logic signed [FW-1:0] ref_re_full, ref_im_full;
    logic signed [OW-1:0] ref_re, ref_im;
    logic                 sum_ok;

    always_comb begin
        ref_re_full = FW'(in_re) * FW'(tw_re) - FW'(in_im) * FW'(tw_im);
        ref_im_full = FW'(in_re) * FW'(tw_im) + FW'(in_im) * FW'(tw_re);
        ref_re      = OW'((ref_re_full + REF_HALF) >>> (CW - 1));
        ref_im      = OW'((ref_im_full + REF_HALF) >>> (CW - 1));
        sum_ok      = (tw_sum == (TW'(tw_re) + TW'(tw_im)));
    end

    p_first_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (vld_q[0] == $past(in_valid)));

    p_last_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(vld_q[PIPE_LAT-2])));

    p_direct_re_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(sum_ok, 3)) |-> (out_re == $past(ref_re, 3)));

    p_direct_im_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(sum_ok, 3)) |-> (out_im == $past(ref_im, 3)));
endmodule

// File: tb/test_twiddle_cmul3.sv
module test_twiddle_cmul3;
    localparam int DW = 16;
    localparam int CW = 16;
    localparam int OW = DW + 2;
    localparam int NS = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_re = '0, in_im = '0;
    logic signed [CW-1:0] tw_re = '0, tw_im = '0;
    logic signed [CW:0]   tw_sum = '0;
    logic                 out_valid;
    logic signed [OW-1:0] out_re, out_im;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    twiddle_cmul3 #(.DW(DW), .CW(CW), .OW(OW)) i_twiddle_cmul3 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_re(in_re), .in_im(in_im), .tw_re(tw_re), .tw_im(tw_im), .tw_sum(tw_sum),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    function automatic logic signed [OW-1:0] rnd(longint full);
        longint r;
        r = (full + (longint'(1) <<< (CW - 2))) >>> (CW - 1);
        return r[OW-1:0];
    endfunction

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(longint ar, longint ai, longint br, longint bi, longint s);
        in_valid = 1'b1;
        in_re = DW'(ar); in_im = DW'(ai);
        tw_re = CW'(br); tw_im = CW'(bi); tw_sum = (CW+1)'(s);
    endtask

    // one sample, consistent coefficient sum, checked after 3 edges
    task automatic one_sample(string req, longint ar, longint ai, longint br, longint bi);
        @(negedge clk);
        drive(ar, ai, br, bi, br + bi);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk({req, " R5 early"}, out_valid, 0);
        @(negedge clk);
        chk({req, " R5 valid"}, out_valid, 1);
        chk({req, " re"}, out_re, rnd(ar*br - ai*bi));
        chk({req, " im"}, out_im, rnd(ar*bi + ai*br));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R6 in reset", out_valid, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R6 after release", out_valid, 0);
    endtask

    task automatic t_basic();
        one_sample("R1 R2 unit", 1000, 0, 16384, 0);
        one_sample("R1 R2 mixed", 1234, -5678, 23170, -23170);
        one_sample("R1 R2 neg j", -20000, 15000, 0, -32767);
    endtask

    task automatic t_round();
        one_sample("R3 plus half", 1, 0, 16384, 0);
        one_sample("R3 minus half", -1, 0, 16384, 0);
        one_sample("R3 im half", 0, 3, 0, 16384);
    endtask

    task automatic t_extremes();
        one_sample("R4 all min", -32768, -32768, -32768, -32768);
        one_sample("R4 max data min coef", 32767, -32768, -32768, 32767);
    endtask

    task automatic t_sum_input();
        longint ar = 300, ai = -700, br = 1000, bi = 2000, s = 9000;
        @(negedge clk);
        drive(ar, ai, br, bi, s);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 valid", out_valid, 1);
        chk("R7 re uses sum", out_re, rnd(ar*s - (ar+ai)*bi));
        chk("R7 im uses sum", out_im, rnd(ar*s + (ai-ar)*br));
    endtask

    task automatic t_stream();
        longint er [NS];
        longint ei [NS];
        for (int i = 0; i < NS + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                chk("R5 stream valid", out_valid, 1);
                chk("R1 stream re", out_re, er[i-3]);
                chk("R2 stream im", out_im, ei[i-3]);
            end
            if (i < NS) begin
                longint ar, ai, br, bi;
                ar = longint'($signed(DW'($urandom)));
                ai = longint'($signed(DW'($urandom)));
                br = longint'($signed(CW'($urandom)));
                bi = longint'($signed(CW'($urandom)));
                if (i == 0) begin ar = -32768; br = -32768; end
                if (i == 1) begin ai = -32768; bi = -32768; end
                er[i] = rnd(ar*br - ai*bi);
                ei[i] = rnd(ar*bi + ai*br);
                drive(ar, ai, br, bi, br + bi);
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk("R5 stream drains", out_valid, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_round();
        t_extremes();
        t_sum_input();
        t_stream();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule